// File: doc/BRIEF.md
# Glitch-free clock group stop controller

This block turns two asynchronous, active-low stop requests into clean enables for several groups of gated clocks. The fast request acts on a fast clock domain that feeds three output groups: processor clocks, memory clocks and graphics clocks. The bus request acts on a slower bus clock domain that feeds a set of bus clock outputs. Each request is synchronized into its own domain before use. A two-bit reach code decides which of the fast-domain groups the fast request halts; the processor group is always included.

Every output also has its own enable bit from a configuration register. The enable register for each output is loaded on the falling edge of its source clock and ANDed with that clock. The gated clock therefore only changes state while the source is low: a stopped output sits at 0 and the first pulse after a restart has a full-width high phase. Once a domain has been released, a minimum run length applies before a new stop is honoured. Bus output 0 is free-running and depends only on its enable bit.

Top module: `clkstop_ctrl`

## Requirements
- R1: While a domain's synchronous active-high reset is asserted, all gated outputs of that domain stay low and produce no rising edge.
- R2: Every high phase of a gated output lasts exactly one high phase of its source clock. A stopped output is held at 0, and the first pulse after a restart is full width.
- R3: Suppose `cpu_stop_n` falls between two fast-clock edges. Processor outputs then pass exactly 2 more rising edges, and every edge from the 3rd onward is suppressed. After the request rises again, the 3rd fast rising edge is the first one passed.
- R4: A fast-domain stop is honoured only after the fast domain has run for at least 100 fast clocks since its last release or since reset. A request that arrives earlier is deferred until that point.
- R5: `halt_mode` sets the reach of the fast stop. 2'b00 halts processor clocks only. 2'b01 halts processor, memory and graphics clocks. 2'b10 halts processor and memory clocks. 2'b11 halts processor and graphics clocks.
- R6: `bus_stop_n` low halts bus outputs 1 to N_BUS-1, with the same edge timing as R3 measured in bus clocks.
- R7: A bus stop is honoured only after the bus domain has run for at least 10 bus clocks since its last release or since reset.
- R8: Bus output 0 ignores `bus_stop_n` and keeps toggling while the other bus outputs are halted.
- R9: A cleared enable bit holds its output at 0 from the next rising edge of the source clock onward, whatever the stop state. This also applies to the free-running bus output.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast source clock for processor, memory and graphics groups |
| rst_fast | input | 1 | Synchronous active-high reset, fast domain |
| clk_bus | input | 1 | Bus source clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| cpu_stop_n | input | 1 | Asynchronous active-low stop request for the fast domain |
| bus_stop_n | input | 1 | Asynchronous active-low stop request for the bus domain |
| halt_mode | input | 2 | Reach code of the fast stop (R5) |
| cpu_en | input | N_CPU (2) | Per-output enables, processor group |
| mem_en | input | N_MEM (4) | Per-output enables, memory group |
| gfx_en | input | N_GFX (2) | Per-output enables, graphics group |
| bus_en | input | N_BUS (6) | Per-output enables, bus group (bit 0 is free-running) |
| cpu_clk_o | output | N_CPU (2) | Gated processor clocks |
| mem_clk_o | output | N_MEM (4) | Gated memory clocks |
| gfx_clk_o | output | N_GFX (2) | Gated graphics clocks |
| bus_clk_o | output | N_BUS (6) | Gated bus clocks |

## Verification
On every clock, the assertions check three things: a halted or disabled output's falling-edge enable is clear, the free-running bus output's enable follows its enable bit alone, and a domain that has just been released cannot halt again in the next cycle. Some behaviours can only be seen over a whole stimulus sequence. These are the exact number of pulses that pass after a request changes, the 100- and 10-clock run windows before a deferred stop takes effect, the four reach codes, and the full width of each restarted pulse. The bench scenarios show these by counting output edges and by timing high phases, beside a cycle model that predicts every output on every edge.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

    // Reach of the fast-domain stop request across output groups.
    typedef enum logic [1:0] {
        REACH_CPU      = 2'b00,
        REACH_ALL      = 2'b01,
        REACH_CPU_MEM  = 2'b10,
        REACH_CPU_GFX  = 2'b11
    } halt_mode_e;

    // Per-group halt decision of the fast domain.
    typedef struct packed {
        logic cpu;
        logic mem;
        logic gfx;
    } group_halt_t;

    function automatic group_halt_t stop_reach(halt_mode_e mode, logic halt);
        group_halt_t g;
        g.cpu = halt;
        g.mem = halt && (mode == REACH_ALL || mode == REACH_CPU_MEM);
        g.gfx = halt && (mode == REACH_ALL || mode == REACH_CPU_GFX);
        return g;
    endfunction

endpackage

// File: rtl/cs_sync.sv
`timescale 1ns/1ps
module cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], async_n};
    end

    assign sync_n = pipe[STAGES-1];
endmodule

// File: rtl/cs_stop_arbiter.sv
`timescale 1ns/1ps
module cs_stop_arbiter #(
    parameter int STAGES  = 2,
    parameter int MIN_RUN = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic stop_n,
    output logic halt
);
    localparam int CW = $clog2(MIN_RUN + 1);
    localparam logic [CW-1:0] RUN_LIM = CW'(MIN_RUN);

    logic          sync_n;
    logic          req;
    logic          halted_q;
    logic [CW-1:0] run_cnt;

    cs_sync #(.STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (stop_n),
        .sync_n  (sync_n)
    );

    assign req  = !sync_n;
    // A new stop needs a full run window; an active stop holds while requested.
    assign halt = req && (halted_q || run_cnt == RUN_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            halted_q <= 1'b0;
            run_cnt  <= '0;
        end else begin
            halted_q <= halt;
            if (halt)
                run_cnt <= '0;
            else if (run_cnt != RUN_LIM)
                run_cnt <= run_cnt + 1'b1;
        end
    end

    // R4 / R7: right after a release the domain cannot halt again.
    assert_min_run_R4: assert property (@(posedge clk) disable iff (rst)
        (halted_q && !halt) |=> !halt);

    // R3 / R6: a stop that is in force stays in force while it is requested.
    assert_hold_while_req_R3: assert property (@(posedge clk) disable iff (rst)
        (halted_q && req) |-> halt);
endmodule

// File: rtl/cs_gate_bank.sv
`timescale 1ns/1ps
module cs_gate_bank #(
    parameter int             N         = 2,
    parameter logic [N-1:0]   FREE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         halt,
    input  logic [N-1:0] en_bits,
    output logic [N-1:0] gclk
);
    logic [N-1:0] en_d;
    logic [N-1:0] en_q;

    assign en_d = en_bits & ~(halt ? ~FREE_MASK : '0);

    // Loaded while the source clock is low, so the gate never cuts a pulse.
    always_ff @(negedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_out
        assign gclk[i] = clk & en_q[i];

        if (FREE_MASK[i]) begin : g_free
            // R8: a free-running output follows its enable bit only.
            assert_free_runs_R8: assert property (@(posedge clk) disable iff (rst)
                en_bits[i] |-> en_q[i]);
        end else begin : g_stoppable
            // R2: a halted output is parked low for the coming edge.
            assert_stop_parks_low_R2: assert property (@(posedge clk) disable iff (rst)
                halt |-> !en_q[i]);
        end

        // R9: a cleared enable bit blocks the next rising edge.
        assert_enable_clear_R9: assert property (@(posedge clk) disable iff (rst)
            !en_bits[i] |-> !en_q[i]);
    end
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int N_CPU        = 2,
    parameter int N_MEM        = 4,
    parameter int N_GFX        = 2,
    parameter int N_BUS        = 6,
    parameter int SYNC_STAGES  = 2,
    parameter int FAST_MIN_RUN = 100,
    parameter int BUS_MIN_RUN  = 10
) (
    input  logic             clk_fast,
    input  logic             rst_fast,
    input  logic             clk_bus,
    input  logic             rst_bus,
    input  logic             cpu_stop_n,
    input  logic             bus_stop_n,
    input  logic [1:0]       halt_mode,
    input  logic [N_CPU-1:0] cpu_en,
    input  logic [N_MEM-1:0] mem_en,
    input  logic [N_GFX-1:0] gfx_en,
    input  logic [N_BUS-1:0] bus_en,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_MEM-1:0] mem_clk_o,
    output logic [N_GFX-1:0] gfx_clk_o,
    output logic [N_BUS-1:0] bus_clk_o
);
    localparam logic [N_BUS-1:0] BUS_FREE = N_BUS'(1);

    logic        fast_halt;
    logic        bus_halt;
    group_halt_t reach;

    cs_stop_arbiter #(.STAGES(SYNC_STAGES), .MIN_RUN(FAST_MIN_RUN)) u_fast_arb (
        .clk    (clk_fast),
        .rst    (rst_fast),
        .stop_n (cpu_stop_n),
        .halt   (fast_halt)
    );

    cs_stop_arbiter #(.STAGES(SYNC_STAGES), .MIN_RUN(BUS_MIN_RUN)) u_bus_arb (
        .clk    (clk_bus),
        .rst    (rst_bus),
        .stop_n (bus_stop_n),
        .halt   (bus_halt)
    );

    assign reach = stop_reach(halt_mode_e'(halt_mode), fast_halt);

    cs_gate_bank #(.N(N_CPU), .FREE_MASK('0)) u_cpu_bank (
        .clk (clk_fast), .rst (rst_fast), .halt (reach.cpu),
        .en_bits (cpu_en), .gclk (cpu_clk_o)
    );

    cs_gate_bank #(.N(N_MEM), .FREE_MASK('0)) u_mem_bank (
        .clk (clk_fast), .rst (rst_fast), .halt (reach.mem),
        .en_bits (mem_en), .gclk (mem_clk_o)
    );

    cs_gate_bank #(.N(N_GFX), .FREE_MASK('0)) u_gfx_bank (
        .clk (clk_fast), .rst (rst_fast), .halt (reach.gfx),
        .en_bits (gfx_en), .gclk (gfx_clk_o)
    );

    cs_gate_bank #(.N(N_BUS), .FREE_MASK(BUS_FREE)) u_bus_bank (
        .clk (clk_bus), .rst (rst_bus), .halt (bus_halt),
        .en_bits (bus_en), .gclk (bus_clk_o)
    );

    // R5: memory or graphics never halts unless the processor group does.
    assert_reach_includes_cpu_R5: assert property (@(posedge clk_fast) disable iff (rst_fast)
        (reach.mem || reach.gfx) |-> reach.cpu);
endmodule

// File: tb/test_clkstop_ctrl.sv
`timescale 1ns/1ps
module test_clkstop_ctrl;
    localparam int N_CPU = 2, N_MEM = 4, N_GFX = 2, N_BUS = 6;
    localparam int FAST_RUN = 100, BUS_RUN = 10;

    logic clk_fast = 1'b0, clk_bus = 1'b0;
    logic rst_fast, rst_bus, cpu_stop_n, bus_stop_n;
    logic [1:0] halt_mode;
    logic [N_CPU-1:0] cpu_en;
    logic [N_MEM-1:0] mem_en;
    logic [N_GFX-1:0] gfx_en;
    logic [N_BUS-1:0] bus_en;
    logic [N_CPU-1:0] cpu_clk_o;
    logic [N_MEM-1:0] mem_clk_o;
    logic [N_GFX-1:0] gfx_clk_o;
    logic [N_BUS-1:0] bus_clk_o;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    string phase = "R1 reset", bphase = "R1 reset";

    clkstop_ctrl i_clkstop_ctrl (
        .clk_fast, .rst_fast, .clk_bus, .rst_bus, .cpu_stop_n, .bus_stop_n,
        .halt_mode, .cpu_en, .mem_en, .gfx_en, .bus_en,
        .cpu_clk_o, .mem_clk_o, .gfx_clk_o, .bus_clk_o
    );

    // 250 MHz fast clock, slower bus clock on an offset grid.
    always #2 clk_fast = ~clk_fast;
    initial begin
        #3;
        forever begin clk_bus = 1'b1; #6; clk_bus = 1'b0; #6; end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- edge counters on sample outputs ----------------
    int c_cpu0 = 0, c_mem0 = 0, c_gfx0 = 0, c_bus0 = 0, c_bus1 = 0;
    wire cpu0 = cpu_clk_o[0];
    wire mem0 = mem_clk_o[0];
    wire gfx0 = gfx_clk_o[0];
    wire bus0 = bus_clk_o[0];
    wire bus1 = bus_clk_o[1];
    always @(posedge cpu0) if (cpu0 === 1'b1) c_cpu0++;
    always @(posedge mem0) if (mem0 === 1'b1) c_mem0++;
    always @(posedge gfx0) if (gfx0 === 1'b1) c_gfx0++;
    always @(posedge bus0) if (bus0 === 1'b1) c_bus0++;
    always @(posedge bus1) if (bus1 === 1'b1) c_bus1++;

    // R2: every high phase is a full source high phase.
    realtime rise_cpu = -1.0, rise_bus = -1.0;
    always @(posedge cpu0) if (cpu0 === 1'b1) rise_cpu = $realtime;
    always @(negedge cpu0) if (rise_cpu >= 0.0) begin
        chk(($realtime - rise_cpu) > 1.99 && ($realtime - rise_cpu) < 2.01,
            "R2 cpu high width ps", int'(($realtime - rise_cpu) * 1000.0), 2000);
        rise_cpu = -1.0;
    end
    always @(posedge bus1) if (bus1 === 1'b1) rise_bus = $realtime;
    always @(negedge bus1) if (rise_bus >= 0.0) begin
        chk(($realtime - rise_bus) > 5.99 && ($realtime - rise_bus) < 6.01,
            "R2 bus high width ps", int'(($realtime - rise_bus) * 1000.0), 6000);
        rise_bus = -1.0;
    end

    // ---------------- cycle model, fast domain ----------------
    int f_run = 0;
    bit f_parked = 0, f_halt = 0, f_live = 0;
    bit [1:0] f_pipe = 2'b11;
    logic [N_CPU-1:0] e_cpu = '0;
    logic [N_MEM-1:0] e_mem = '0;
    logic [N_GFX-1:0] e_gfx = '0;

    always @(posedge clk_fast) begin
        if (rst_fast) begin
            f_run = 0; f_parked = 0; f_halt = 0; f_pipe = 2'b11;
        end else begin
            f_parked = f_halt;
            if (f_halt) f_run = 0;
            else if (f_run < FAST_RUN) f_run++;
            f_pipe = {f_pipe[0], cpu_stop_n};
            f_halt = !f_pipe[1] && (f_parked || f_run == FAST_RUN);
        end
        #1;
        if (f_live) begin
            chk(cpu_clk_o === e_cpu, {phase, " cpu model"}, int'(cpu_clk_o), int'(e_cpu));
            chk(mem_clk_o === e_mem, {phase, " mem model"}, int'(mem_clk_o), int'(e_mem));
            chk(gfx_clk_o === e_gfx, {phase, " gfx model"}, int'(gfx_clk_o), int'(e_gfx));
        end
    end

    always @(negedge clk_fast) begin
        bit mh, gh;
        f_live = 1;
        // R5 reach table: 00 cpu, 01 all, 10 cpu+mem, 11 cpu+gfx
        mh = f_halt && (halt_mode == 2'b01 || halt_mode == 2'b10);
        gh = f_halt && (halt_mode == 2'b01 || halt_mode == 2'b11);
        if (rst_fast) begin
            e_cpu = '0; e_mem = '0; e_gfx = '0;
        end else begin
            e_cpu = f_halt ? '0 : cpu_en;
            e_mem = mh ? '0 : mem_en;
            e_gfx = gh ? '0 : gfx_en;
        end
    end

    // ---------------- cycle model, bus domain ----------------
    int b_run = 0;
    bit b_parked = 0, b_halt = 0, b_live = 0;
    bit [1:0] b_pipe = 2'b11;
    logic [N_BUS-1:0] e_bus = '0;

    always @(posedge clk_bus) begin
        if (rst_bus) begin
            b_run = 0; b_parked = 0; b_halt = 0; b_pipe = 2'b11;
        end else begin
            b_parked = b_halt;
            if (b_halt) b_run = 0;
            else if (b_run < BUS_RUN) b_run++;
            b_pipe = {b_pipe[0], bus_stop_n};
            b_halt = !b_pipe[1] && (b_parked || b_run == BUS_RUN);
        end
        #1;
        if (b_live)
            chk(bus_clk_o === e_bus, {bphase, " bus model"}, int'(bus_clk_o), int'(e_bus));
    end

    always @(negedge clk_bus) begin
        b_live = 1;
        if (rst_bus) e_bus = '0;
        else e_bus = b_halt ? (bus_en & N_BUS'(1)) : bus_en;   // R8: bit 0 free
    end

    // ---------------- stimulus ----------------
    task automatic fwait(input int n);
        repeat (n) @(posedge clk_fast);
        #1.5;
    endtask
    task automatic bwait(input int n);
        repeat (n) @(posedge clk_bus);
        #1.5;
    endtask

    int s_cpu, s_mem, s_gfx, s_b0, s_b1;

    initial begin
        rst_fast = 1; rst_bus = 1; cpu_stop_n = 1; bus_stop_n = 1;
        halt_mode = 2'b00;
        cpu_en = '1; mem_en = '1; gfx_en = '1; bus_en = '1;
        fwait(8);
        chk(c_cpu0 == 0 && c_mem0 == 0 && c_gfx0 == 0, "R1 fast pulses in reset", c_cpu0 + c_mem0 + c_gfx0, 0);
        chk(c_bus0 == 0 && c_bus1 == 0, "R1 bus pulses in reset", c_bus0 + c_bus1, 0);
        rst_fast = 0; rst_bus = 0;

        // R4: early request deferred until 100 running clocks
        phase = "R4 early stop";
        cpu_stop_n = 0;
        s_cpu = c_cpu0;
        fwait(60);
        chk(c_cpu0 - s_cpu == 60, "R4 deferred stop", c_cpu0 - s_cpu, 60);
        fwait(100);
        cpu_stop_n = 1;
        fwait(10);
        fwait(110);

        // R3: stop and release latency
        phase = "R3 latency";
        cpu_stop_n = 0; s_cpu = c_cpu0;
        fwait(6);
        chk(c_cpu0 - s_cpu == 2, "R3 edges after stop", c_cpu0 - s_cpu, 2);
        cpu_stop_n = 1; s_cpu = c_cpu0;
        fwait(6);
        chk(c_cpu0 - s_cpu == 4, "R3 edges after release", c_cpu0 - s_cpu, 4);
        // R4: immediate re-stop runs 100 clocks first
        phase = "R4 min run";
        cpu_stop_n = 0;
        fwait(124);
        chk(c_cpu0 - s_cpu == 100, "R4 run window after release", c_cpu0 - s_cpu, 100);
        cpu_stop_n = 1;
        fwait(5);

        // R5: reach codes
        for (int m = 0; m < 4; m++) begin
            bit ms, gs;
            phase = "R5 reach";
            halt_mode = 2'(m);
            ms = (m == 1 || m == 2);
            gs = (m == 1 || m == 3);
            fwait(110);
            cpu_stop_n = 0;
            fwait(5);
            s_cpu = c_cpu0; s_mem = c_mem0; s_gfx = c_gfx0;
            fwait(10);
            chk(c_cpu0 - s_cpu == 0, "R5 cpu halted", c_cpu0 - s_cpu, 0);
            chk(c_mem0 - s_mem == (ms ? 0 : 10), "R5 mem reach", c_mem0 - s_mem, ms ? 0 : 10);
            chk(c_gfx0 - s_gfx == (gs ? 0 : 10), "R5 gfx reach", c_gfx0 - s_gfx, gs ? 0 : 10);
            cpu_stop_n = 1;
            fwait(5);
        end

        // R9: enable bits
        phase = "R9 enables";
        cpu_en = 2'b10; mem_en = 4'b0101; gfx_en = '0;
        fwait(10);
        s_cpu = c_cpu0; s_mem = c_mem0; s_gfx = c_gfx0;
        fwait(10);
        chk(c_cpu0 - s_cpu == 0, "R9 cpu0 disabled", c_cpu0 - s_cpu, 0);
        chk(c_mem0 - s_mem == 10, "R9 mem0 enabled", c_mem0 - s_mem, 10);
        chk(c_gfx0 - s_gfx == 0, "R9 gfx0 disabled", c_gfx0 - s_gfx, 0);
        cpu_en = '1; mem_en = '1; gfx_en = '1;
        phase = "R2 idle";

        // R6 / R8: bus stop latency, free output
        bphase = "R6 bus stop";
        bwait(2);
        bus_stop_n = 0; s_b0 = c_bus0; s_b1 = c_bus1;
        bwait(6);
        chk(c_bus1 - s_b1 == 2, "R6 bus edges after stop", c_bus1 - s_b1, 2);
        chk(c_bus0 - s_b0 == 6, "R8 free bus output runs", c_bus0 - s_b0, 6);
        bus_stop_n = 1; s_b0 = c_bus0; s_b1 = c_bus1;
        bwait(6);
        chk(c_bus1 - s_b1 == 4, "R6 bus edges after release", c_bus1 - s_b1, 4);
        // R7: re-stop runs 10 bus clocks first
        bphase = "R7 bus min run";
        bus_stop_n = 0;
        bwait(20);
        chk(c_bus1 - s_b1 == 10, "R7 bus run window", c_bus1 - s_b1, 10);
        chk(c_bus0 - s_b0 == 26, "R8 free output during stop", c_bus0 - s_b0, 26);
        bus_stop_n = 1;
        bwait(4);

        // R9: free output still obeys its enable
        bphase = "R9 bus enable";
        bus_en[0] = 1'b0;
        bwait(3);
        s_b0 = c_bus0;
        bwait(5);
        chk(c_bus0 - s_b0 == 0, "R9 free output disabled", c_bus0 - s_b0, 0);
        bus_en = '1;
        bwait(4);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule